// File: doc/BRIEF.md
# Frame-Dithered PWM Generator

This block produces a pulse-width modulated output whose duty resolution is finer than one clock. A plain counter PWM with a period of 2^PERIOD_BITS clocks can only place the falling edge on whole clocks, so it offers just 2^PERIOD_BITS + 1 levels. This generator groups 2^FRAME_BITS periods into a frame. In each period the high time is either a coarse base width or that width plus one clock. The extra clocks are spread over the frame so that the number of high clocks per frame equals the commanded duty word.

The duty word is PERIOD_BITS + FRAME_BITS bits wide. Its upper PERIOD_BITS bits are the base width. Its lower FRAME_BITS bits are the fraction, which an accumulator turns into a per-period carry. Software or a control loop presents a word with a one-cycle strobe. The word is recorded at once but only takes effect at the next frame boundary, so every frame is generated from a single word. A frame-start pulse lets downstream logic align to the dither pattern. The frame should be short enough that its repetition rate lies above the bandwidth of the filter that follows.

Top module: `dpwm_gen`

## Requirements
- R1: While reset is high, and in the cycle after any reset edge, pwm_o and frame_o are low; reset also clears the stored duty word to zero, so the first frame after reset is all low.
- R2: frame_o is high for exactly one clock every 2^(PERIOD_BITS+FRAME_BITS) clocks. The first pulse comes at the first clock edge after reset is released, and each pulse marks the first output cycle of a frame.
- R3: Within every period of 2^PERIOD_BITS clocks, pwm_o is high for one contiguous run starting at the period's first clock, and the run is base or base+1 clocks long. Here base is duty bits [PERIOD_BITS+FRAME_BITS-1:FRAME_BITS].
- R4: Let f be duty bits [FRAME_BITS-1:0] and k the index of a period within its frame, starting at 0. Period k is extended by one clock exactly when floor((k+1)·f / 2^FRAME_BITS) > floor(k·f / 2^FRAME_BITS). The spreading restarts from zero at every frame.
- R5: For any duty word other than all ones, the number of high clocks in a frame equals the duty word read as an unsigned number.
- R6: An all-ones duty word keeps pwm_o high on every clock of the frame; an all-zero word keeps it low on every clock.
- R7: A word strobed with duty_vld_i during a frame (not on its last clock) leaves the rest of that frame unchanged and is used from the next frame. When several words are strobed within one frame, the last one wins.
- R8: A word strobed on the last clock of a frame, i.e. sampled at the edge that starts the next frame, is used for that next frame.
- R9: Without a new strobe, the last accepted word is repeated frame after frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| duty_i | input | PERIOD_BITS+FRAME_BITS | Duty word: base width in the upper bits, fraction in the lower bits |
| duty_vld_i | input | 1 | One-cycle strobe that records duty_i |
| pwm_o | output | 1 | Registered PWM output |
| frame_o | output | 1 | Registered one-clock pulse on the first cycle of each frame |

## Verification
The load strobe and the frame boundary can land in the same clock: a word presented on the last clock of a frame must be steered straight into the new frame, bypassing the holding register. The bench provokes this by strobing every word of an exhaustive sweep exactly on that clock. It then judges every output cycle of the following frame against the arithmetic pattern for the new word, not the old one. A second sweep strobes words in mid-frame, including two strobes in one frame, to show that the current frame is left untouched and the last word wins.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

   // Class of the active duty word, decided once per cycle by the holder.
   typedef enum logic [1:0] {
      LVL_LOW    = 2'd0,   // word is zero: output held low
      LVL_DITHER = 2'd1,   // base width plus accumulator carry
      LVL_HIGH   = 2'd2    // word is all ones: output held high
   } lvl_e;

   // Largest supported total duty width.
   localparam int DPWM_MAX_BITS = 24;

endpackage

// File: rtl/dpwm_timer.sv
module dpwm_timer #(
   parameter int PERIOD_BITS = 2,
   parameter int FRAME_BITS  = 3
) (
   input  logic                   clk_i,
   input  logic                   rst_i,
   output logic [PERIOD_BITS-1:0] cnt_o,
   output logic                   per_start_o,
   output logic                   frm_start_o
);
   localparam int W = PERIOD_BITS + FRAME_BITS;

   // Position in the frame: low bits count clocks, high bits count periods.
   logic [W-1:0] pos_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) pos_q <= '0;
      else       pos_q <= pos_q + {{(W-1){1'b0}}, 1'b1};
   end

   assign cnt_o       = pos_q[PERIOD_BITS-1:0];
   assign per_start_o = (pos_q[PERIOD_BITS-1:0] == '0);
   assign frm_start_o = (pos_q == '0);

endmodule

// File: rtl/dpwm_duty_hold.sv
module dpwm_duty_hold
   import dpwm_pkg::*;
#(
   parameter int W = 5
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic [W-1:0] duty_i,
   input  logic         vld_i,
   input  logic         frm_start_i,
   output logic [W-1:0] act_o,
   output lvl_e         lvl_o
);
   logic [W-1:0] pend_q;   // most recent strobed word
   logic [W-1:0] cur_q;    // word governing the running frame

   // At a boundary the newest word wins, even one strobed in this very cycle.
   always_comb begin
      if (frm_start_i) act_o = vld_i ? duty_i : pend_q;
      else             act_o = cur_q;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         pend_q <= '0;
         cur_q  <= '0;
      end else begin
         if (vld_i) pend_q <= duty_i;
         cur_q <= act_o;
      end
   end

   always_comb begin
      if (act_o == '0)      lvl_o = LVL_LOW;
      else if (&act_o)      lvl_o = LVL_HIGH;
      else                  lvl_o = LVL_DITHER;
   end

endmodule

// File: rtl/dpwm_spreader.sv
module dpwm_spreader #(
   parameter int FRAME_BITS = 3
) (
   input  logic                  clk_i,
   input  logic                  rst_i,
   input  logic [FRAME_BITS-1:0] frac_i,
   input  logic                  per_start_i,
   input  logic                  frm_start_i,
   output logic                  ext_o
);
   logic [FRAME_BITS-1:0] acc_q;
   logic                  ext_q;
   logic [FRAME_BITS-1:0] acc_base;
   logic [FRAME_BITS:0]   sum;

   // The accumulator restarts from zero on the first period of a frame.
   assign acc_base = frm_start_i ? '0 : acc_q;
   assign sum      = {1'b0, acc_base} + {1'b0, frac_i};

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         acc_q <= '0;
         ext_q <= 1'b0;
      end else if (per_start_i) begin
         acc_q <= sum[FRAME_BITS-1:0];
         ext_q <= sum[FRAME_BITS];
      end
   end

   // Carry is live in the first clock of a period and held for the rest.
   assign ext_o = per_start_i ? sum[FRAME_BITS] : ext_q;

endmodule

// File: rtl/dpwm_shaper.sv
module dpwm_shaper
   import dpwm_pkg::*;
#(
   parameter int PERIOD_BITS = 2
) (
   input  logic [PERIOD_BITS-1:0] cnt_i,
   input  logic [PERIOD_BITS-1:0] base_i,
   input  logic                   ext_i,
   input  lvl_e                   lvl_i,
   output logic                   on_o
);
   logic [PERIOD_BITS:0] width;
   logic                 below;

   assign width = {1'b0, base_i} + {{PERIOD_BITS{1'b0}}, ext_i};
   assign below = ({1'b0, cnt_i} < width);

   always_comb begin
      unique case (lvl_i)
         LVL_LOW:  on_o = 1'b0;
         LVL_HIGH: on_o = 1'b1;
         default:  on_o = below;
      endcase
   end

endmodule

// File: rtl/dpwm_gen.sv
module dpwm_gen
   import dpwm_pkg::*;
#(
   parameter int PERIOD_BITS = 2,
   parameter int FRAME_BITS  = 3
) (
   input  logic                              clk_i,
   input  logic                              rst_i,
   input  logic [PERIOD_BITS+FRAME_BITS-1:0] duty_i,
   input  logic                              duty_vld_i,
   output logic                              pwm_o,
   output logic                              frame_o
);
   localparam int W = PERIOD_BITS + FRAME_BITS;

   // Elaboration-time parameter checks.
   generate
      if (PERIOD_BITS < 1) begin : g_bad_period
         $error("PERIOD_BITS must be at least 1");
      end
      if (FRAME_BITS < 1) begin : g_bad_frame
         $error("FRAME_BITS must be at least 1");
      end
      if (W > DPWM_MAX_BITS) begin : g_bad_width
         $error("PERIOD_BITS+FRAME_BITS exceeds the supported width");
      end
   endgenerate

   logic [PERIOD_BITS-1:0] cnt;
   logic                   per_start;
   logic                   frm_start;
   logic [W-1:0]           act;
   lvl_e                   lvl;
   logic                   ext;
   logic                   on;

   dpwm_timer #(
      .PERIOD_BITS (PERIOD_BITS),
      .FRAME_BITS  (FRAME_BITS)
   ) u_timer (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .cnt_o       (cnt),
      .per_start_o (per_start),
      .frm_start_o (frm_start)
   );

   dpwm_duty_hold #(
      .W (W)
   ) u_hold (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .duty_i      (duty_i),
      .vld_i       (duty_vld_i),
      .frm_start_i (frm_start),
      .act_o       (act),
      .lvl_o       (lvl)
   );

   dpwm_spreader #(
      .FRAME_BITS (FRAME_BITS)
   ) u_spread (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .frac_i      (act[FRAME_BITS-1:0]),
      .per_start_i (per_start),
      .frm_start_i (frm_start),
      .ext_o       (ext)
   );

   dpwm_shaper #(
      .PERIOD_BITS (PERIOD_BITS)
   ) u_shape (
      .cnt_i  (cnt),
      .base_i (act[W-1:FRAME_BITS]),
      .ext_i  (ext),
      .lvl_i  (lvl),
      .on_o   (on)
   );

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         pwm_o   <= 1'b0;
         frame_o <= 1'b0;
      end else begin
         pwm_o   <= on;
         frame_o <= frm_start;
      end
   end

endmodule

// File: rtl/dpwm_chk.sv
module dpwm_chk #(
   parameter int PERIOD_BITS = 2,
   parameter int FRAME_BITS  = 3
) (
   input logic                              clk_i,
   input logic                              rst_i,
   input logic [PERIOD_BITS+FRAME_BITS-1:0] duty_i,
   input logic                              duty_vld_i,
   input logic                              pwm_o,
   input logic                              frame_o
);
   localparam int W = PERIOD_BITS + FRAME_BITS;

   // Checker-side model of the output position and of the frame's word.
   logic [W-1:0]         pos_m;
   logic [W-1:0]         pend_m;
   logic [W-1:0]         fduty_m;
   logic [W:0]           fhi_m;
   logic [PERIOD_BITS:0] phi_m;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         pos_m   <= '1;
         pend_m  <= '0;
         fduty_m <= '0;
         fhi_m   <= '0;
         phi_m   <= '0;
      end else begin
         pos_m <= pos_m + {{(W-1){1'b0}}, 1'b1};
         if (duty_vld_i) pend_m <= duty_i;
         if (pos_m == '1) begin
            fduty_m <= duty_vld_i ? duty_i : pend_m;
            fhi_m   <= '0;
         end else begin
            fhi_m <= fhi_m + {{W{1'b0}}, pwm_o};
         end
         if (&pos_m[PERIOD_BITS-1:0]) phi_m <= '0;
         else                         phi_m <= phi_m + {{PERIOD_BITS{1'b0}}, pwm_o};
      end
   end

   logic [W:0]           frame_tot;
   logic [W:0]           frame_exp;
   logic [PERIOD_BITS:0] period_tot;
   logic [PERIOD_BITS:0] base_m;

   assign frame_tot  = fhi_m + {{W{1'b0}}, pwm_o};
   assign frame_exp  = (&fduty_m) ? {1'b1, {W{1'b0}}} : {1'b0, fduty_m};
   assign period_tot = phi_m + {{PERIOD_BITS{1'b0}}, pwm_o};
   assign base_m     = {1'b0, fduty_m[W-1:FRAME_BITS]};

   // R1
   reset_quiet_chk: assert property (@(posedge clk_i)
      rst_i |=> (!pwm_o && !frame_o));

   // R2
   frame_pos_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      frame_o == (pos_m == '0));

   // R3
   single_run_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (!pwm_o && !(&pos_m[PERIOD_BITS-1:0])) |=> !pwm_o);

   // R3
   period_width_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (&pos_m[PERIOD_BITS-1:0]) |->
         ((period_tot == base_m) ||
          (period_tot == base_m + {{PERIOD_BITS{1'b0}}, 1'b1})));

   // R5
   frame_avg_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (pos_m == '1) |-> (frame_tot == frame_exp));

endmodule

bind dpwm_gen dpwm_chk #(
   .PERIOD_BITS (PERIOD_BITS),
   .FRAME_BITS  (FRAME_BITS)
) u_chk (
   .clk_i      (clk_i),
   .rst_i      (rst_i),
   .duty_i     (duty_i),
   .duty_vld_i (duty_vld_i),
   .pwm_o      (pwm_o),
   .frame_o    (frame_o)
);

// File: tb/sim_dpwm_gen.sv
module sim_dpwm_gen;
   localparam int P  = 2;
   localparam int F  = 3;
   localparam int W  = P + F;
   localparam int FC = 1 << W;
   localparam int PC = 1 << P;
   localparam int NP = 1 << F;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         vld = 1'b0;
   logic [W-1:0] din = '0;
   logic         pwm;
   logic         frm;

   always #5 clk = ~clk;

   dpwm_gen #(.PERIOD_BITS(P), .FRAME_BITS(F)) u0 (
      .clk_i(clk), .rst_i(rst), .duty_i(din), .duty_vld_i(vld),
      .pwm_o(pwm), .frame_o(frm)
   );

   int           n_cmp = 0;
   int           n_bad = 0;
   int           pos;
   logic [W-1:0] cur_m;
   logic [W-1:0] pend_m;
   bit           primed;
   bit           mid_load;
   int           per_hi;
   int           frm_hi;
   string        tag;
   bit           done = 0;

   function automatic int carry_of(input logic [W-1:0] d, input int k);
      int f;
      f = int'(d) & (NP - 1);
      return (((k + 1) * f) >> F) - ((k * f) >> F);
   endfunction

   function automatic int exp_pwm(input logic [W-1:0] d, input int p);
      if (d == '1) return 1;
      return ((p & (PC - 1)) < ((int'(d) >> F) + carry_of(d, p >> P))) ? 1 : 0;
   endfunction

   task automatic chk(input string r, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d (pos %0d word %0d)", r, act, exp, pos, cur_m);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   // Called at a falling edge: judge the outputs, then drive the next edge.
   task automatic step(input bit v, input logic [W-1:0] w);
      bit at_edge;
      if (primed) begin
         if (pos == 0) frm_hi = 0;
         if ((pos & (PC - 1)) == 0) per_hi = 0;
         chk(tag, int'(pwm), exp_pwm(cur_m, pos));
         chk("R2", int'(frm), (pos == 0) ? 1 : 0);
         per_hi += int'(pwm);
         frm_hi += int'(pwm);
         if (((pos & (PC - 1)) == PC - 1) && (cur_m != '1))
            chk("R4", per_hi, (int'(cur_m) >> F) + carry_of(cur_m, pos >> P));
         if (pos == FC - 1)
            chk((cur_m == '1) ? "R6" : "R5", frm_hi, (cur_m == '1) ? FC : int'(cur_m));
      end
      vld = v;
      din = w;
      at_edge = (pos == FC - 1);
      if (v) begin
         pend_m = w;
         if (!at_edge) mid_load = 1;
      end
      @(posedge clk);
      pos = (pos + 1) % FC;
      if (pos == 0) begin
         cur_m = pend_m;
         if (v && at_edge)                    tag = "R8";
         else if (mid_load)                   tag = "R7";
         else if (cur_m == '0 || cur_m == '1) tag = "R6";
         else                                 tag = "R3";
         mid_load = 0;
      end
      primed = 1;
      @(negedge clk);
   endtask

   // One full frame; strobes w1 at offset a1 and w2 at offset a2 (-1 = none).
   task automatic run_frame(input logic [W-1:0] w1, input int a1,
                            input logic [W-1:0] w2, input int a2);
      for (int p = 0; p < FC; p++) begin
         if (p == a2)      step(1'b1, w2);
         else if (p == a1) step(1'b1, w1);
         else              step(1'b0, '0);
      end
   endtask

   task automatic do_reset();
      rst = 1'b1;
      vld = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      // R1: outputs quiet under reset
      n_cmp++; if (pwm !== 1'b0) begin n_bad++; $display("FAIL R1: got %0b expected 0 on pwm_o", pwm); end
      n_cmp++; if (frm !== 1'b0) begin n_bad++; $display("FAIL R1: got %0b expected 0 on frame_o", frm); end
      rst    = 1'b0;
      pos    = FC - 1;
      pend_m = '0;
      cur_m  = '0;
      primed = 0;
      mid_load = 0;
      tag    = "R1";
      step(1'b0, '0);
      // first frame after reset carries the cleared word: R1
      tag = "R1";
   endtask

   initial begin
      @(negedge clk);
      do_reset();
      run_frame('0, -1, '0, -1);             // R1: idle frame all low
      // R8: every word strobed on the boundary clock, used at once
      for (int d = 0; d < FC; d++) run_frame(W'(d), FC - 1, '0, -1);
      run_frame('0, -1, '0, -1);             // R9: last word repeats
      run_frame('0, -1, '0, -1);
      // R7: mid-frame strobes, current frame untouched
      for (int d = FC - 1; d >= 0; d--) run_frame(W'(d), d % (FC - 1), '0, -1);
      // R7: two strobes in one frame, last wins
      run_frame(W'(3), 2, W'(FC - 2), 20);
      run_frame(W'(FC - 1), 5, W'(9), 30);
      run_frame('0, -1, '0, -1);
      // R1: reset in mid-run clears the stored word
      for (int p = 0; p < 7; p++) step(1'b0, '0);
      do_reset();
      run_frame(W'(21), FC - 1, '0, -1);
      run_frame('1, FC - 1, '0, -1);          // R6: all ones
      run_frame('0, -1, '0, -1);
      done = 1;
      summary();
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         n_bad++;
         $display("FAIL R2 watchdog: got no completion expected end of run");
         summary();
         $finish;
      end
   end

endmodule